// File: doc/BRIEF.md
# Encoded-Ratio Clock Strobe Generator

This block produces single-cycle enable strobes for several clock domains from one fast clock. Four domains (processor, fast bus, slow bus, memory) each take a 4-bit ratio code. The code is decoded through a fixed non-linear ratio table, not used as a binary count. A peripheral source strobe runs at the source rate or at half of it. A display chain sits on top of the peripheral strobe: a device strobe with its own ratio, and a pixel strobe with a much wider ratio. A timer strobe follows the slow-bus domain. Gate bits can silence the timer strobe and the display strobes.

The counters advance on source ticks. When the multiplier stage is on and not bypassed, every clock is a source tick. Otherwise only the cycles marked by the reference tick input count. Software writes ratio fields into a pending copy. The fields take effect only when the commit bit is written. Each counter then picks up its new ratio at its own terminal count, so no strobe period is ever cut short or stretched.

Top module: `clk_ratio_gen`

## Requirements
- R1: A domain ratio code c decodes as follows. Codes 0 to 9 give divide-by 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32. Codes 10 to 15 give divide-by 1. The control word (address 0) holds the codes at these bit positions: processor in bits 3:0, fast bus in 7:4, slow bus in 11:8, memory in 15:12.
- R2: A control write whose bit 22 is 0 updates only the pending fields, which read back at once. No strobe spacing changes.
- R3: After a commit, each counter finishes the period in progress with its old ratio. It runs the new ratio from the next period onward.
- R4: Bit 22 of the control word reads 1 from the cycle after a commit write until every committed counter has loaded the new setting. It then reads 0.
- R5: Control bit 21 selects the peripheral strobe rate. A 1 gives a strobe on every source tick. A 0 gives a strobe on every second source tick.
- R6: Control bits 20:16 hold the display device ratio minus one (1 to 32). That ratio counts peripheral strobes.
- R7: The pixel register (address 2, bits 10:0) holds the pixel ratio minus one (1 to 2048). That ratio counts peripheral strobes and takes effect at the pixel counter's next terminal count, with no commit needed.
- R8: In the gate register (address 1), bit 1 set silences the timer strobe, and bit 10 set silences both display strobes. The counters keep running while gated, and a clear bit lets the strobe run. The timer strobe follows the slow-bus strobe.
- R9: With pll_on=1 and pll_bypass=0, counters advance on every clock. Otherwise they advance only on cycles where ref_tick=1.
- R10: Reset sets every ratio code to 0, bit 21 to 1, the display and pixel fields to 0, and all gate bits to 0. Address 0 then reads 0x0020_0000 and every strobe is high in the first cycle after reset when the source is active.
- R11: Each strobe is a one-cycle pulse, repeated exactly every N source ticks for a ratio N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock |
| rst_n | input | 1 | asynchronous reset, active low |
| pll_on | input | 1 | multiplied source enabled |
| pll_bypass | input | 1 | multiplied source bypassed |
| ref_tick | input | 1 | raw reference tick, one cycle wide |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | write address |
| wr_data | input | DATA_W | write data |
| rd_addr | input | ADDR_W | read address |
| rd_data | output | DATA_W | read data, combinational |
| cpu_stb | output | 1 | processor domain strobe |
| fbus_stb | output | 1 | fast bus domain strobe |
| sbus_stb | output | 1 | slow bus domain strobe |
| mem_stb | output | 1 | memory domain strobe |
| per_stb | output | 1 | peripheral source strobe |
| tmr_stb | output | 1 | timer strobe, gated |
| lcd_dev_stb | output | 1 | display device strobe, gated |
| lcd_pix_stb | output | 1 | display pixel strobe, gated |

## Verification
The assertions check four properties on every cycle. Domain strobes fire only on source ticks. Gated strobes stay silent. Display strobes coincide with peripheral strobes. The active domain ratios hold still while no commit is pending. The bench scenarios cover what a cycle-local property cannot express: the spacing between strobes for every ratio code, the completion of the old period across a commit, the clearing of the commit flag, the phase kept through gating, and the effect of switching the tick source.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

   localparam int CODE_W       = 4;
   localparam int LIM_W        = 5;
   localparam int LCD_W        = 5;
   localparam int NUM_DOM      = 4;
   localparam int NUM_TRACK    = NUM_DOM + 2;
   localparam int COMMIT_BIT   = 22;
   localparam int TMR_GATE_BIT = 1;
   localparam int LCD_GATE_BIT = 10;

   // bit 21 peripheral rate, 20:16 display device ratio-1, 15:0 domain codes
   typedef struct packed {
      logic                            per_full;
      logic [LCD_W-1:0]                lcd_lim;
      logic [NUM_DOM-1:0][CODE_W-1:0]  code;
   } ratio_cfg_t;

   localparam int CFG_W = $bits(ratio_cfg_t);

   localparam ratio_cfg_t CFG_RST = '{per_full: 1'b1, lcd_lim: '0, code: '0};

   // ratio code to terminal count (ratio minus one)
   function automatic logic [LIM_W-1:0] code_to_lim(input logic [CODE_W-1:0] code);
      case (code)
         4'd1:    return LIM_W'(1);
         4'd2:    return LIM_W'(2);
         4'd3:    return LIM_W'(3);
         4'd4:    return LIM_W'(5);
         4'd5:    return LIM_W'(7);
         4'd6:    return LIM_W'(11);
         4'd7:    return LIM_W'(15);
         4'd8:    return LIM_W'(23);
         4'd9:    return LIM_W'(31);
         default: return LIM_W'(0);
      endcase
   endfunction

endpackage

// File: rtl/strobe_divider.sv
module strobe_divider #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] lim_next,
   output logic         fire,
   output logic         wrap,
   output logic [W-1:0] lim_q
);

   logic [W-1:0] cnt_q;

   if (W < 1) begin : g_bad_width
      $error("strobe_divider: W must be at least 1");
   end

   assign fire = tick && (cnt_q == '0);
   assign wrap = tick && (cnt_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (tick) begin
         if (wrap) begin
            cnt_q <= '0;
            lim_q <= lim_next;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
   import clk_ratio_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int PIX_W     = 11,
   parameter int CTRL_ADDR = 0,
   parameter int GATE_ADDR = 1,
   parameter int PIX_ADDR  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [NUM_TRACK-1:0] took,
   output ratio_cfg_t           live_cfg,
   output logic                 busy,
   output logic                 gate_tmr,
   output logic                 gate_lcd,
   output logic [PIX_W-1:0]     pix_lim
);

   ratio_cfg_t           pend_q;
   logic [NUM_TRACK-1:0] wait_q;
   logic                 ctrl_wr, commit_wr, gate_wr, pix_wr;

   assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
   assign gate_wr   = wr_en && (wr_addr == ADDR_W'(GATE_ADDR));
   assign pix_wr    = wr_en && (wr_addr == ADDR_W'(PIX_ADDR));
   assign commit_wr = ctrl_wr && wr_data[COMMIT_BIT];
   assign busy      = |wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= CFG_RST;
         live_cfg <= CFG_RST;
         wait_q   <= '0;
      end else begin
         if (ctrl_wr) pend_q <= ratio_cfg_t'(wr_data[CFG_W-1:0]);
         if (commit_wr) begin
            live_cfg <= ratio_cfg_t'(wr_data[CFG_W-1:0]);
            wait_q   <= '1;
         end else begin
            wait_q   <= wait_q & ~took;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_tmr <= 1'b0;
         gate_lcd <= 1'b0;
         pix_lim  <= '0;
      end else begin
         if (gate_wr) begin
            gate_tmr <= wr_data[TMR_GATE_BIT];
            gate_lcd <= wr_data[LCD_GATE_BIT];
         end
         if (pix_wr) pix_lim <= wr_data[PIX_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
         rd_data[CFG_W-1:0]  = pend_q;
         rd_data[COMMIT_BIT] = busy;
      end else if (rd_addr == ADDR_W'(GATE_ADDR)) begin
         rd_data[TMR_GATE_BIT] = gate_tmr;
         rd_data[LCD_GATE_BIT] = gate_lcd;
      end else if (rd_addr == ADDR_W'(PIX_ADDR)) begin
         rd_data[PIX_W-1:0] = pix_lim;
      end
   end

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
   import clk_ratio_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int PIX_W     = 11,
   parameter int CTRL_ADDR = 0,
   parameter int GATE_ADDR = 1,
   parameter int PIX_ADDR  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pll_on,
   input  logic              pll_bypass,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              cpu_stb,
   output logic              fbus_stb,
   output logic              sbus_stb,
   output logic              mem_stb,
   output logic              per_stb,
   output logic              tmr_stb,
   output logic              lcd_dev_stb,
   output logic              lcd_pix_stb
);

   localparam int SLOW_DOM = 2;

   if (DATA_W <= COMMIT_BIT || DATA_W <= LCD_GATE_BIT) begin : g_bad_data
      $error("clk_ratio_gen: DATA_W too narrow for the control word");
   end
   if (PIX_W < 1 || PIX_W > DATA_W) begin : g_bad_pix
      $error("clk_ratio_gen: PIX_W out of range");
   end
   if (CTRL_ADDR == GATE_ADDR || CTRL_ADDR == PIX_ADDR || GATE_ADDR == PIX_ADDR) begin : g_bad_map
      $error("clk_ratio_gen: register addresses overlap");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || GATE_ADDR >= (1 << ADDR_W) || PIX_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("clk_ratio_gen: address does not fit ADDR_W");
   end

   ratio_cfg_t                        live_cfg;
   logic                              busy, gate_tmr, gate_lcd;
   logic [PIX_W-1:0]                  pix_lim;
   logic                              src_tick;
   logic [NUM_DOM-1:0]                dom_fire, dom_wrap;
   logic [NUM_DOM-1:0][LIM_W-1:0]     dom_lim;
   logic                              per_fire, per_wrap;
   logic [0:0]                        per_lim_next, per_lim_q;
   logic                              lcd_fire, lcd_wrap, pix_fire, pix_wrap;
   logic [LCD_W-1:0]                  lcd_lim_q;
   logic [PIX_W-1:0]                  pix_lim_q;

   assign src_tick = (pll_on && !pll_bypass) || ref_tick;

   clk_ratio_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W),
      .CTRL_ADDR(CTRL_ADDR), .GATE_ADDR(GATE_ADDR), .PIX_ADDR(PIX_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .took     ({lcd_wrap, per_wrap, dom_wrap}),
      .live_cfg (live_cfg),
      .busy     (busy),
      .gate_tmr (gate_tmr),
      .gate_lcd (gate_lcd),
      .pix_lim  (pix_lim)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic [LIM_W-1:0] lim_next;
      assign lim_next = code_to_lim(live_cfg.code[d]);
      strobe_divider #(.W(LIM_W)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (src_tick),
         .lim_next (lim_next),
         .fire     (dom_fire[d]),
         .wrap     (dom_wrap[d]),
         .lim_q    (dom_lim[d])
      );
   end

   assign per_lim_next = {~live_cfg.per_full};

   strobe_divider #(.W(1)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (src_tick),
      .lim_next (per_lim_next),
      .fire     (per_fire),
      .wrap     (per_wrap),
      .lim_q    (per_lim_q)
   );

   strobe_divider #(.W(LCD_W)) u_lcd (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (per_fire),
      .lim_next (live_cfg.lcd_lim),
      .fire     (lcd_fire),
      .wrap     (lcd_wrap),
      .lim_q    (lcd_lim_q)
   );

   strobe_divider #(.W(PIX_W)) u_pix (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (per_fire),
      .lim_next (pix_lim),
      .fire     (pix_fire),
      .wrap     (pix_wrap),
      .lim_q    (pix_lim_q)
   );

   assign cpu_stb     = dom_fire[0];
   assign fbus_stb    = dom_fire[1];
   assign sbus_stb    = dom_fire[SLOW_DOM];
   assign mem_stb     = dom_fire[3];
   assign per_stb     = per_fire;
   assign tmr_stb     = dom_fire[SLOW_DOM] && !gate_tmr;
   assign lcd_dev_stb = lcd_fire && !gate_lcd;
   assign lcd_pix_stb = pix_fire && !gate_lcd;

endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk
   import clk_ratio_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          pll_on,
   input logic                          pll_bypass,
   input logic                          ref_tick,
   input logic                          wr_en,
   input logic [ADDR_W-1:0]             wr_addr,
   input logic [DATA_W-1:0]             wr_data,
   input logic                          cpu_stb,
   input logic                          fbus_stb,
   input logic                          sbus_stb,
   input logic                          mem_stb,
   input logic                          per_stb,
   input logic                          tmr_stb,
   input logic                          lcd_dev_stb,
   input logic                          lcd_pix_stb,
   input logic                          busy,
   input logic                          gate_tmr,
   input logic                          gate_lcd,
   input logic [NUM_DOM-1:0][LIM_W-1:0] dom_lim
);

   logic commit_wr;
   assign commit_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[COMMIT_BIT];

   assert_src_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stb || fbus_stb || sbus_stb || mem_stb || per_stb) |-> (ref_tick || (pll_on && !pll_bypass)));

   assert_tmr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_tmr |-> !tmr_stb);

   assert_tmr_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_stb |-> sbus_stb);

   assert_lcd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lcd |-> !(lcd_dev_stb || lcd_pix_stb));

   assert_lcd_dev_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_dev_stb |-> per_stb);

   assert_lcd_pix_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_pix_stb |-> per_stb);

   assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !commit_wr) |=> !busy);

   assert_ratio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(dom_lim));

endmodule

bind clk_ratio_gen clk_ratio_gen_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pll_on      (pll_on),
   .pll_bypass  (pll_bypass),
   .ref_tick    (ref_tick),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .cpu_stb     (cpu_stb),
   .fbus_stb    (fbus_stb),
   .sbus_stb    (sbus_stb),
   .mem_stb     (mem_stb),
   .per_stb     (per_stb),
   .tmr_stb     (tmr_stb),
   .lcd_dev_stb (lcd_dev_stb),
   .lcd_pix_stb (lcd_pix_stb),
   .busy        (busy),
   .gate_tmr    (gate_tmr),
   .gate_lcd    (gate_lcd),
   .dom_lim     (dom_lim)
);

// File: tb/tb_clk_ratio_gen.sv
module tb_clk_ratio_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pll_on = 1'b1, pll_bypass = 1'b0, ref_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        cpu_stb, fbus_stb, sbus_stb, mem_stb, per_stb, tmr_stb, lcd_dev_stb, lcd_pix_stb;
   logic [7:0]  stbv;

   int checks = 0, errors = 0, cyc = 0;
   int last_t [8];
   int exp_q [8][$];
   string tag_q [8][$];

   always #2.5 clk = ~clk;

   clk_ratio_gen dut (
      .clk, .rst_n, .pll_on, .pll_bypass, .ref_tick,
      .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
      .cpu_stb, .fbus_stb, .sbus_stb, .mem_stb, .per_stb,
      .tmr_stb, .lcd_dev_stb, .lcd_pix_stb
   );

   // channel order: 0 cpu 1 fbus 2 sbus 3 mem 4 per 5 lcd_dev 6 lcd_pix 7 tmr
   assign stbv = {tmr_stb, lcd_pix_stb, lcd_dev_stb, per_stb, mem_stb, sbus_stb, fbus_stb, cpu_stb};

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   // monitor: pops an expected gap for each observed strobe
   initial begin
      for (int i = 0; i < 8; i++) last_t[i] = 0;
      forever begin
         @(negedge clk);
         cyc++;
         for (int ch = 0; ch < 8; ch++) begin
            if (stbv[ch]) begin
               if (exp_q[ch].size() > 0) begin
                  int g;
                  string t;
                  g = exp_q[ch].pop_front();
                  t = tag_q[ch].pop_front();
                  check($sformatf("%s gap ch%0d", t, ch), cyc - last_t[ch], g);
               end
               last_t[ch] = cyc;
            end
         end
      end
   end

   // reference tick every third clock
   initial begin
      int rc = 0;
      forever begin
         @(negedge clk);
         rc = (rc + 1) % 3;
         ref_tick = (rc == 0);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic int ratio_of(input int code);
      case (code)
         0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 6;
         5: return 8;  6: return 12; 7: return 16; 8: return 24; 9: return 32;
         default: return 1;
      endcase
   endfunction

   function automatic logic [31:0] mk(input int c, input int f, input int s, input int m,
                                      input int lcd, input int per);
      return (32'(per) << 21) | (32'(lcd) << 16) | (32'(m) << 12) | (32'(s) << 8) |
             (32'(f) << 4) | 32'(c);
   endfunction

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      forever begin
         reg_rd(2'd0, v);
         if (!v[22]) break;
         @(negedge clk);
      end
   endtask

   task automatic commit(input logic [31:0] d);
      reg_wr(2'd0, d | (32'd1 << 22));
      wait_idle();
      repeat (80) @(negedge clk);
   endtask

   task automatic expect_gaps(input int ch, input int gap, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_q[ch].push_back(gap);
         tag_q[ch].push_back(tag);
      end
   endtask

   task automatic drain();
      forever begin
         int pend = 0;
         for (int ch = 0; ch < 8; ch++) pend += exp_q[ch].size();
         if (pend == 0) break;
         @(negedge clk);
      end
      #1;
   endtask

   task automatic wait_stb(input int ch);
      forever begin
         @(negedge clk);
         #1;
         if (stbv[ch]) break;
      end
   endtask

   initial begin
      logic [31:0] v;
      int n_tmr, n_sbus, n_lcd;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R10: every strobe present right after reset
      check("R10 strobes after reset", int'(stbv), 8'hFF);
      reg_rd(2'd0, v); check("R10 control reset", v, 32'h0020_0000);
      reg_rd(2'd1, v); check("R10 gate reset", v, 0);
      reg_rd(2'd2, v); check("R10 pixel reset", v, 0);

      // R1 / R11: every code on every domain
      for (int c = 0; c < 16; c++) begin
         commit(mk(c, (c + 1) % 16, (c + 2) % 16, (c + 3) % 16, 0, 1));
         reg_rd(2'd0, v);
         check("R1 code readback", int'(v[15:0]),
               ((c + 3) % 16) * 4096 + ((c + 2) % 16) * 256 + ((c + 1) % 16) * 16 + c);
         for (int d = 0; d < 4; d++) expect_gaps(d, ratio_of((c + d) % 16), 3, "R1 R11");
         drain();
      end

      // R2: pending write without commit leaves spacing alone
      reg_wr(2'd0, mk(9, 9, 9, 9, 0, 1));
      reg_rd(2'd0, v);
      check("R2 pending readback", int'(v[15:0]), 16'h9999);
      check("R2 no busy", int'(v[22]), 0);
      repeat (40) @(negedge clk);
      expect_gaps(0, 1, 3, "R2");
      expect_gaps(3, 3, 3, "R2");
      drain();

      // R3 / R4: commit mid-period
      commit(mk(9, 0, 0, 0, 0, 1));
      wait_stb(0);
      repeat (5) @(negedge clk);
      expect_gaps(0, 32, 1, "R3");
      expect_gaps(0, 2, 2, "R3");
      reg_wr(2'd0, mk(1, 0, 0, 0, 0, 1) | (32'd1 << 22));
      reg_rd(2'd0, v);
      check("R4 busy after commit", int'(v[22]), 1);
      drain();
      reg_rd(2'd0, v);
      check("R4 busy cleared", int'(v[22]), 0);

      // R5: peripheral rate
      commit(mk(0, 0, 0, 0, 0, 0));
      expect_gaps(4, 2, 4, "R5");
      drain();
      commit(mk(0, 0, 0, 0, 0, 1));
      expect_gaps(4, 1, 4, "R5");
      drain();

      // R6: display device ratio 5 on half-rate peripheral strobe
      commit(mk(0, 0, 0, 0, 4, 0));
      expect_gaps(5, 10, 3, "R6");
      expect_gaps(6, 2, 3, "R7");
      drain();

      // R7: pixel ratio 7 without commit
      reg_wr(2'd2, 32'd6);
      reg_rd(2'd2, v);
      check("R7 pixel readback", v, 6);
      repeat (80) @(negedge clk);
      expect_gaps(6, 14, 3, "R7");
      drain();

      // R8: gating
      reg_wr(2'd1, 32'd1 << 1);
      n_tmr = 0; n_sbus = 0; n_lcd = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk); #1;
         n_tmr += int'(tmr_stb); n_sbus += int'(sbus_stb); n_lcd += int'(lcd_dev_stb);
      end
      check("R8 timer gated", n_tmr, 0);
      check("R8 slow bus runs", n_sbus, 64);
      check("R8 lcd untouched", n_lcd > 0 ? 1 : 0, 1);
      reg_wr(2'd1, 32'd1 << 10);
      reg_rd(2'd1, v);
      check("R8 gate readback", v, 32'h400);
      n_tmr = 0; n_lcd = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk); #1;
         n_tmr += int'(tmr_stb); n_lcd += int'(lcd_dev_stb) + int'(lcd_pix_stb);
      end
      check("R8 timer resumed", n_tmr, 64);
      check("R8 lcd gated", n_lcd, 0);
      reg_wr(2'd1, 32'd0);
      wait_stb(5);
      expect_gaps(5, 10, 2, "R8");
      drain();

      // R9: source selection
      commit(mk(1, 0, 0, 0, 0, 1));
      pll_on = 1'b0;
      repeat (40) @(negedge clk);
      expect_gaps(0, 6, 3, "R9");
      expect_gaps(1, 3, 3, "R9");
      drain();
      pll_on = 1'b1; pll_bypass = 1'b1;
      repeat (40) @(negedge clk);
      expect_gaps(0, 6, 3, "R9");
      drain();
      pll_bypass = 1'b0;
      repeat (40) @(negedge clk);
      expect_gaps(0, 2, 3, "R9");
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule